// File: doc/BRIEF.md
# Four-Channel Prioritized Interrupt Aggregator

This block collects the interrupt requests of four independent serial channels. Each channel presents six level-sensitive cause flags. The block ranks them by a fixed priority and registers a 3-bit identification code for the most urgent cause that is pending. Each channel drives its own interrupt output. A channel's code and interrupt drop on their own once software services the cause and the channel lowers the flag.

A host with only one interrupt line uses the combined output. Each channel contributes to it only when its bit in a mask register is set. A status register shows which channels are requesting service, whatever the mask holds. Software therefore takes the shared interrupt, polls the status register, and then reads the identification codes of the channels that are requesting.

Top module: `quad_irq_combiner`

## Requirements
- R1: A channel's interrupt output is high exactly when at least one of its six cause flags was high at the previous clock edge.
- R2: Cause 0 has the highest priority and cause 5 the lowest. The identification code is the index of the highest-priority set cause plus one, which gives values 1 to 6.
- R3: When none of a channel's causes is set, its identification code reads 0 and its interrupt output is low from the next edge on.
- R4: Channels are independent. Channel c uses cause bits c*6 to c*6+5 of the request bus, and its interrupt output is bit c.
- R5: The global interrupt is registered. It is high exactly when, at the previous edge, some channel had its interrupt output high and its mask bit set.
- R6: Reading address 1 returns the channel interrupt outputs in bits 3:0 and zeros above, whatever the mask holds.
- R7: A write to address 0 loads bits 3:0 of the write data into the mask. The mask reads back at address 0 in bits 3:0, and the new value gates the global interrupt from the following edge.
- R8: After reset the mask is 0, all identification codes are 0, and every interrupt output is low.
- R9: Address 2 returns the channel 0 code in bits 2:0 and the channel 1 code in bits 6:4. Address 3 returns the channel 2 and channel 3 codes in the same positions. All other bits read 0.
- R10: Writes to addresses 1, 2 and 3 leave the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cause_req | input | 24 | Cause flags, six per channel |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ch_irq | output | 4 | Per-channel interrupt outputs |
| glb_irq | output | 1 | Masked global interrupt |

## Verification
The assertions check the following on every cycle:
- a set top-priority cause always gives code 1;
- a channel with no causes set always clears;
- codes stay inside their legal range;
- a mask write lands one edge later and the mask holds otherwise;
- the global output follows the masked pending state of the previous edge;
- the status read matches the channel outputs.

Only the bench's scenarios can show the remaining behaviour. That covers the exact codes for mixed cause patterns, the packing of codes into the read bytes, isolation between channels, and the full two-edge path from a cause flag to the global interrupt under changing masks.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned REG_AW = 2;
  localparam int unsigned REG_DW = 8;

  typedef enum logic [REG_AW-1:0] {
    RA_MASK  = 2'd0,
    RA_STAT  = 2'd1,
    RA_ID_LO = 2'd2,
    RA_ID_HI = 2'd3
  } reg_addr_e;

  localparam int unsigned ID_SLOT_W    = 4;
  localparam int unsigned IDS_PER_BYTE = REG_DW / ID_SLOT_W;
endpackage

// File: rtl/irq_chan_arb.sv
module irq_chan_arb #(
  parameter int unsigned N_CAUSE = 6,
  parameter int unsigned ID_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CAUSE-1:0] req,
  output logic [ID_W-1:0]    id_q,
  output logic               irq
);
  localparam logic [ID_W-1:0] ID_IDLE = '0;
  localparam logic [ID_W-1:0] ID_MAX  = ID_W'(N_CAUSE);

  // Highest priority is the lowest index; the code is index plus one.
  function automatic logic [ID_W-1:0] top_cause(input logic [N_CAUSE-1:0] r);
    logic [ID_W-1:0] v;
    v = ID_IDLE;
    for (int i = N_CAUSE - 1; i >= 0; i--) begin
      if (r[i]) v = ID_W'(i + 1);
    end
    return v;
  endfunction

  logic [ID_W-1:0] id_next;
  assign id_next = top_cause(req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) id_q <= ID_IDLE;
    else        id_q <= id_next;
  end

  assign irq = (id_q != ID_IDLE);

  p_top_cause_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req[0])) |-> (id_q == ID_W'(1)));

  p_clear_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(req) == '0)) |-> (id_q == ID_IDLE && !irq));

  p_id_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    id_q <= ID_MAX);

  p_pending_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(req) != '0)) |-> irq);
endmodule

// File: rtl/irq_glb_ctrl.sv
module irq_glb_ctrl #(
  parameter int unsigned N_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_mask,
  input  logic [N_CH-1:0] wdata,
  input  logic [N_CH-1:0] pend,
  output logic [N_CH-1:0] mask_q,
  output logic            glb_q
);
  logic [N_CH-1:0] route;
  logic            any_route;

  assign route     = pend & mask_q;
  assign any_route = |route;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      glb_q  <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= wdata;
      glb_q <= any_route;
    end
  end

  p_mask_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(wdata)));

  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));

  p_glb_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (glb_q == $past(|(pend & mask_q))));

  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mask_q) == '0) |-> !glb_q);
endmodule

// File: rtl/quad_irq_combiner.sv
module quad_irq_combiner
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_CH    = 4,
  parameter int unsigned N_CAUSE = 6,
  parameter int unsigned ID_W    = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_CH*N_CAUSE-1:0] cause_req,
  input  logic [1:0]              reg_addr,
  input  logic                    reg_we,
  input  logic [7:0]              reg_wdata,
  output logic [7:0]              reg_rdata,
  output logic [N_CH-1:0]         ch_irq,
  output logic                    glb_irq
);
  localparam int unsigned ID_BASE = 2;

  logic [ID_W-1:0] ch_id [N_CH];
  logic [N_CH-1:0] mask_q;
  logic            wr_mask;

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    irq_chan_arb #(.N_CAUSE(N_CAUSE), .ID_W(ID_W)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (cause_req[c*N_CAUSE +: N_CAUSE]),
      .id_q  (ch_id[c]),
      .irq   (ch_irq[c])
    );
  end

  assign wr_mask = reg_we && (reg_addr == RA_MASK);

  irq_glb_ctrl #(.N_CH(N_CH)) u_glb (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_mask (wr_mask),
    .wdata   (reg_wdata[N_CH-1:0]),
    .pend    (ch_irq),
    .mask_q  (mask_q),
    .glb_q   (glb_irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RA_MASK)      reg_rdata[N_CH-1:0] = mask_q;
    else if (reg_addr == RA_STAT) reg_rdata[N_CH-1:0] = ch_irq;
    else begin
      for (int c = 0; c < N_CH; c++) begin
        if (reg_addr == 2'(ID_BASE + c / IDS_PER_BYTE))
          reg_rdata[(c % IDS_PER_BYTE)*ID_SLOT_W +: ID_W] = ch_id[c];
      end
    end
  end

  p_status_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RA_STAT) |-> (reg_rdata == 8'(ch_irq)));

  p_glb_needs_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    glb_irq |-> $past(ch_irq) != '0);
endmodule

// File: tb/quad_irq_combiner_tb.sv
`timescale 1ns/1ps
module quad_irq_combiner_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] cause_req = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [3:0]  ch_irq;
  logic        glb_irq;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic [3:0] m_mask = '0;
  logic [3:0] m_pend = '0;
  logic       m_glb  = 1'b0;
  logic [2:0] m_id [4] = '{default: 3'd0};

  always #2 clk = ~clk;

  quad_irq_combiner u_dut (
    .clk(clk), .rst_n(rst_n), .cause_req(cause_req), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ch_irq(ch_irq), .glb_irq(glb_irq)
  );

  function automatic logic [2:0] pick(input logic [5:0] r);
    logic [2:0] e = 3'd0;
    for (int i = 0; i < 6; i++) if (r[i] && e == 3'd0) e = 3'(i + 1);
    return e;
  endfunction

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return {4'd0, m_mask};
      2'd1:    return {4'd0, m_pend};
      2'd2:    return {1'b0, m_id[1], 1'b0, m_id[0]};
      default: return {1'b0, m_id[3], 1'b0, m_id[2]};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [23:0] rq, input logic we, input logic [1:0] a,
                      input logic [7:0] wd);
    logic nglb;
    cause_req = rq; reg_we = we; reg_addr = a; reg_wdata = wd;
    @(posedge clk); #1;
    nglb = |(m_pend & m_mask);
    if (we && a == 2'd0) m_mask = wd[3:0];
    for (int c = 0; c < 4; c++) begin
      m_id[c]   = pick(rq[c*6 +: 6]);
      m_pend[c] = (m_id[c] != 3'd0);
    end
    m_glb = nglb;
    chk("R1/R4 ch_irq", 32'(ch_irq), 32'(m_pend));
    chk("R5 glb_irq", 32'(glb_irq), 32'(m_glb));
    case (a)
      2'd0: chk("R7/R10 mask read", 32'(reg_rdata), 32'(exp_read(a)));
      2'd1: chk("R6 status read", 32'(reg_rdata), 32'(exp_read(a)));
      default: chk("R2/R3/R9 id read", 32'(reg_rdata), 32'(exp_read(a)));
    endcase
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    reg_addr = a; reg_we = 1'b0; #0.5;
    chk(tag, 32'(reg_rdata), 32'(exp_read(a)));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned s;
    s = $urandom(32'd4242);
    cause_req = 24'hFFFFFF;
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    chk("R8 ch_irq reset", 32'(ch_irq), 32'd0);
    chk("R8 glb reset", 32'(glb_irq), 32'd0);
    rd(2'd0, "R8 mask reset");
    rd(2'd2, "R8 id lo reset");
    rd(2'd3, "R8 id hi reset");
    rst_n = 1'b1;

    // R2: all causes on ch0 -> code 1; only cause 5 on ch1 -> code 6
    step({6'b000000, 6'b000000, 6'b100000, 6'b111111}, 1'b0, 2'd2, 8'd0);
    // R2: middle priority cause 3 on ch2, causes 2 and 4 on ch3 -> 4 and 3
    step({6'b010100, 6'b001000, 6'b000000, 6'b000000}, 1'b0, 2'd3, 8'd0);
    // R6: status with mask zero still shows pending; glb stays low (R8)
    step({6'b010100, 6'b001000, 6'b000000, 6'b000001}, 1'b0, 2'd1, 8'd0);
    // R7: enable ch2 only
    step({6'b010100, 6'b001000, 6'b000000, 6'b000001}, 1'b1, 2'd0, 8'hF4);
    step({6'b010100, 6'b001000, 6'b000000, 6'b000001}, 1'b0, 2'd0, 8'd0);
    // R3: service everything, codes clear
    step(24'd0, 1'b0, 2'd2, 8'd0);
    step(24'd0, 1'b0, 2'd3, 8'd0);
    // R10: writes to read-only addresses ignored
    step(24'd0, 1'b1, 2'd1, 8'h0B);
    step(24'd0, 1'b1, 2'd2, 8'h0B);
    step(24'd0, 1'b1, 2'd3, 8'h0B);
    step(24'd0, 1'b0, 2'd0, 8'd0);
    // R4: only ch1 pending but ch1 unmasked -> glb stays low
    step({18'd0, 6'b000100} << 6, 1'b0, 2'd1, 8'd0);
    step({18'd0, 6'b000100} << 6, 1'b0, 2'd2, 8'd0);

    // Constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic [23:0] rq;
      logic        we;
      rq = 24'($urandom) & 24'($urandom);
      if (($urandom % 5) == 0) rq = '0;
      we = (($urandom % 4) == 0);
      step(rq, we, 2'($urandom), 8'($urandom));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule